// File: doc/BRIEF.md
# Descriptor-Driven PCM Sample Mover

This block is a single audio bus-master channel. It walks a table of region descriptors held in system memory and moves 32-bit stereo sample words, each one a pair of 16-bit samples, between a buffer in memory and a codec sample stream. In playback it reads memory and presents the words on the play stream. In capture it accepts words from the capture stream and writes them to memory. Each descriptor names one buffer region. Flags in the descriptor can raise an interrupt when the region ends, stop the channel, or redirect the walk to another descriptor, so the table can loop in hardware without software help.

Software programs the table address and then writes the command register to start the channel. It can pause the channel and resume it later without losing its place, or halt it outright. A status register records region ends and bus errors, and reading it clears it. The memory side is a plain request/acknowledge port. Both codec streams use valid/ready handshakes.

The register port has four word slots. Slot 0 is the command, slot 1 the status, slot 2 the table address and slot 3 the current transfer pointer. Read data appears one cycle after the read strobe.

Top module: `pcm_desc_dma`

## Requirements
- R1: A descriptor occupies 8 bytes. The buffer base address is at the descriptor address and the size word is at that address plus 4. The walker fetches the base first, then the size word, and the next sequential descriptor starts 8 bytes further on.
- R2: In playback (command bit 3 = 0), the memory words from the region base upward are presented on the play stream in address order. The byte count is taken from size-word bits [15:0], and bits [1:0] are dropped, so a region moves count/4 words. While a memory request waits for acknowledge, its address is held.
- R3: In capture (command bit 3 = 1), each accepted capture-stream word is written to consecutive memory words from the region base upward. Nothing is written past the region.
- R4: Command bit 2 = 1 swaps the two bytes inside each 16-bit half of every moved word, in both directions. Bit 2 = 0 moves words unchanged.
- R5: When the last word of a region whose size-word bit 30 is set has moved, status bit 0 is set. If that set coincides with a status read, the set wins. The irq output is high whenever any status bit is set.
- R6: When a region whose size-word bit 31 is set (and bit 29 clear) completes, the channel stops. Command bits [1:0] read back 00 and no further memory requests are made.
- R7: A descriptor with size-word bit 29 set moves no data. The next descriptor is fetched from its base field. This jump takes precedence over bit 31.
- R8: A descriptor whose count is below 4 moves no data and sets no status. The walk then continues, or stops if bit 31 is set.
- R9: Command bits [1:0] = 11 (pause) stop all memory requests and stream handshakes. Writing 01 afterwards resumes with the next word, so no word is lost or repeated.
- R10: Writing 00 to command bits [1:0] halts the channel, and memory requests cease. The next enable (01) starts again from the descriptor at the table address. The value 10 acts like 00.
- R11: After reset, all registers read 0 and irq is low. A status read returns the value before clearing, then clears both status bits.
- R12: An acknowledge with mem_err set counts as a bus error. It sets status bit 1 and stops the channel (command bits [1:0] become 00).
- R13: Register slot 3 returns the address of the next data word to move, which is the region base plus 4 times the words already moved in that region.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (status read clears) |
| reg_addr | input | 2 | Register slot: 0 command, 1 status, 2 table address, 3 pointer |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid the cycle after reg_rd |
| irq | output | 1 | Interrupt, high while any status bit is set |
| mem_req | output | 1 | Memory request, held until mem_ack |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory completes the request this cycle |
| mem_err | input | 1 | Memory reports a bus error with mem_ack |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |
| play_data | output | 32 | Playback sample word |
| play_valid | output | 1 | Playback word available |
| play_ready | input | 1 | Codec accepts playback word |
| cap_data | input | 32 | Capture sample word |
| cap_valid | input | 1 | Capture word available |
| cap_ready | output | 1 | Channel accepts capture word |

## Verification
Some properties are checked on every clock cycle. When paused, the channel keeps the bus and both streams quiet. A disabled command always returns the walker to idle. A bus error always raises the error status together with the stop. A stop or region end always lands in the registers with the right priority over software. A waiting request keeps its address steady. The descriptor walk itself can only be shown by the bench's scenarios: sequential fetch, jump looping, count truncation, zero-count skip, byte swapping, and resuming after a pause at an arbitrary point. These run as sweeps over counts and byte order in both directions, against sample words the bench computes from their addresses.

// File: rtl/pdd_pkg.sv
package pdd_pkg;
  // size-word flag positions (decoded by the walker)
  localparam int FLG_STOP = 31;
  localparam int FLG_MARK = 30;
  localparam int FLG_JUMP = 29;

  // command register fields
  localparam int CMD_SWAP = 2;
  localparam int CMD_DIR  = 3;
  localparam int CMD_W    = 4;
  localparam int STS_W    = 2;

  // register slots
  localparam logic [1:0] RA_CMD = 2'd0;
  localparam logic [1:0] RA_STS = 2'd1;
  localparam logic [1:0] RA_TBL = 2'd2;
  localparam logic [1:0] RA_PTR = 2'd3;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'b00,
    MODE_RUN  = 2'b01,
    MODE_RSV  = 2'b10,
    MODE_HOLD = 2'b11
  } mode_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_FBASE, ST_FSIZE, ST_EVAL,
    ST_MRD, ST_PUSH, ST_PULL, ST_MWR, ST_FIN
  } wst_e;
endpackage

// File: rtl/pdd_swap.sv
module pdd_swap #(
  parameter int WORD_W = 32,
  parameter int LANE_W = 16
) (
  input  logic              en,
  input  logic [WORD_W-1:0] din,
  output logic [WORD_W-1:0] dout
);
  localparam int LANES = WORD_W / LANE_W;
  localparam int BPL   = LANE_W / 8;

  logic [WORD_W-1:0] rev;

  // reverse byte order inside every sample lane
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    for (genvar b = 0; b < BPL; b++) begin : g_byte
      assign rev[l*LANE_W + b*8 +: 8] = din[l*LANE_W + (BPL-1-b)*8 +: 8];
    end
  end

  assign dout = en ? rev : din;
endmodule

// File: rtl/pdd_regs.sv
module pdd_regs
  import pdd_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [1:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          irq,
  input  logic [AW-1:0] cur_ptr,
  input  logic          set_eop,
  input  logic          set_err,
  input  logic          stop,
  output mode_e         mode,
  output logic          dir_cap,
  output logic          big_end,
  output logic [AW-1:0] tbase
);
  logic [CMD_W-1:0] cmd_q;
  logic [STS_W-1:0] sts_q;
  logic [AW-1:0]    tbl_q;
  logic             wr_cmd, rd_sts;

  assign wr_cmd = reg_wr && (reg_addr == RA_CMD);
  assign rd_sts = reg_rd && (reg_addr == RA_STS);

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q <= '0;
    end else if (wr_cmd) begin
      cmd_q <= reg_wdata[CMD_W-1:0];
    end else if (stop) begin
      cmd_q[1:0] <= MODE_OFF;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tbl_q <= '0;
    end else if (reg_wr && (reg_addr == RA_TBL)) begin
      tbl_q <= reg_wdata[AW-1:0];
    end
  end

  // read-to-clear status, a new event in the same cycle wins
  always_ff @(posedge clk) begin
    if (rst) begin
      sts_q <= '0;
    end else begin
      sts_q <= (rd_sts ? '0 : sts_q) | {set_err, set_eop};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      case (reg_addr)
        RA_CMD:  reg_rdata <= 32'(cmd_q);
        RA_STS:  reg_rdata <= 32'(sts_q);
        RA_TBL:  reg_rdata <= 32'(tbl_q);
        default: reg_rdata <= 32'(cur_ptr);
      endcase
    end
  end

  assign irq     = |sts_q;
  assign mode    = mode_e'(cmd_q[1:0]);
  assign dir_cap = cmd_q[CMD_DIR];
  assign big_end = cmd_q[CMD_SWAP];
  assign tbase   = tbl_q;

  p_stop_clears_r6: assert property (@(posedge clk) disable iff (rst)
    (stop && !wr_cmd) |=> (cmd_q[1:0] == 2'b00));
  p_mark_wins_r5: assert property (@(posedge clk) disable iff (rst)
    set_eop |=> sts_q[0]);
  p_read_clears_r11: assert property (@(posedge clk) disable iff (rst)
    (rd_sts && !set_eop && !set_err) |=> (sts_q == '0));
endmodule

// File: rtl/pdd_walker.sv
module pdd_walker
  import pdd_pkg::*;
#(
  parameter int AW    = 32,
  parameter int CNT_W = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  mode_e         mode,
  input  logic          dir_cap,
  input  logic          big_end,
  input  logic [AW-1:0] tbase,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic          mem_ack,
  input  logic          mem_err,
  input  logic [31:0]   mem_rdata,
  output logic [31:0]   play_data,
  output logic          play_valid,
  input  logic          play_ready,
  input  logic [31:0]   cap_data,
  input  logic          cap_valid,
  output logic          cap_ready,
  output logic [AW-1:0] cur_ptr,
  output logic          set_eop,
  output logic          set_err,
  output logic          stop
);
  localparam int WC_W = CNT_W - 2;
  localparam logic [AW-1:0] WSTEP = AW'(4);
  localparam logic [AW-1:0] DSTEP = AW'(8);

  wst_e            st_q;
  logic [AW-1:0]   dptr_q, cur_q;
  logic [WC_W-1:0] left_q;
  logic [31:0]     data_q, sw_in, sw_out;
  logic            eot_q, eop_q, jmp_q;
  logic            run, acc, bad, push, pull, last, skip_end;

  assign run  = (mode == MODE_RUN);
  assign last = (left_q == WC_W'(1));

  always_comb begin
    mem_req = run && (st_q inside {ST_FBASE, ST_FSIZE, ST_MRD, ST_MWR});
    mem_we  = run && (st_q == ST_MWR);
    case (st_q)
      ST_FBASE: mem_addr = dptr_q;
      ST_FSIZE: mem_addr = dptr_q + WSTEP;
      default:  mem_addr = cur_q;
    endcase
  end

  assign acc        = mem_req && mem_ack;
  assign bad        = acc && mem_err;
  assign play_valid = run && (st_q == ST_PUSH);
  assign cap_ready  = run && (st_q == ST_PULL);
  assign push       = play_valid && play_ready;
  assign pull       = cap_valid && cap_ready;
  assign mem_wdata  = data_q;
  assign play_data  = data_q;
  assign cur_ptr    = cur_q;

  // one swap unit on the ingress side serves both directions
  assign sw_in = dir_cap ? cap_data : mem_rdata;
  pdd_swap #(.WORD_W(32), .LANE_W(16)) u_swap (
    .en(big_end), .din(sw_in), .dout(sw_out)
  );

  assign skip_end = (st_q == ST_EVAL) && !jmp_q && (left_q == '0) && eot_q;
  assign set_eop  = run && (st_q == ST_FIN) && eop_q;
  assign set_err  = bad;
  assign stop     = bad || (run && (((st_q == ST_FIN) && eot_q) || skip_end));

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      dptr_q <= '0;
      cur_q  <= '0;
      left_q <= '0;
      data_q <= '0;
      eot_q  <= 1'b0;
      eop_q  <= 1'b0;
      jmp_q  <= 1'b0;
    end else if (mode == MODE_OFF || mode == MODE_RSV) begin
      st_q <= ST_IDLE;
    end else if (run) begin
      if (bad) begin
        st_q <= ST_IDLE;
      end else begin
        case (st_q)
          ST_IDLE: begin
            dptr_q <= tbase;
            st_q   <= ST_FBASE;
          end
          ST_FBASE: if (acc) begin
            cur_q <= mem_rdata[AW-1:0];
            st_q  <= ST_FSIZE;
          end
          ST_FSIZE: if (acc) begin
            eot_q  <= mem_rdata[FLG_STOP];
            eop_q  <= mem_rdata[FLG_MARK];
            jmp_q  <= mem_rdata[FLG_JUMP];
            left_q <= mem_rdata[CNT_W-1:2];
            st_q   <= ST_EVAL;
          end
          ST_EVAL: begin
            if (jmp_q) begin
              dptr_q <= cur_q;
              st_q   <= ST_FBASE;
            end else if (left_q == '0) begin
              if (eot_q) begin
                st_q <= ST_IDLE;
              end else begin
                dptr_q <= dptr_q + DSTEP;
                st_q   <= ST_FBASE;
              end
            end else begin
              st_q <= dir_cap ? ST_PULL : ST_MRD;
            end
          end
          ST_MRD: if (acc) begin
            data_q <= sw_out;
            st_q   <= ST_PUSH;
          end
          ST_PUSH: if (push) begin
            cur_q  <= cur_q + WSTEP;
            left_q <= left_q - WC_W'(1);
            st_q   <= last ? ST_FIN : ST_MRD;
          end
          ST_PULL: if (pull) begin
            data_q <= sw_out;
            st_q   <= ST_MWR;
          end
          ST_MWR: if (acc) begin
            cur_q  <= cur_q + WSTEP;
            left_q <= left_q - WC_W'(1);
            st_q   <= last ? ST_FIN : ST_PULL;
          end
          ST_FIN: begin
            if (eot_q) begin
              st_q <= ST_IDLE;
            end else begin
              dptr_q <= dptr_q + DSTEP;
              st_q   <= ST_FBASE;
            end
          end
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end

  p_hold_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_HOLD) |-> (!mem_req && !play_valid && !cap_ready));
  p_halt_idle_r10: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_OFF || mode == MODE_RSV) |=> (st_q == ST_IDLE));
  p_err_stops_r12: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_ack && mem_err) |-> (set_err && stop));
  p_addr_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (!mem_req || $stable(mem_addr)));
endmodule

// File: rtl/pcm_desc_dma.sv
module pcm_desc_dma
  import pdd_pkg::*;
#(
  parameter int AW    = 32,
  parameter int CNT_W = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [1:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          irq,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic          mem_ack,
  input  logic          mem_err,
  input  logic [31:0]   mem_rdata,
  output logic [31:0]   play_data,
  output logic          play_valid,
  input  logic          play_ready,
  input  logic [31:0]   cap_data,
  input  logic          cap_valid,
  output logic          cap_ready
);
  mode_e         mode;
  logic          dir_cap, big_end, set_eop, set_err, stop;
  logic [AW-1:0] tbase, cur_ptr;

  pdd_regs #(.AW(AW)) u_regs (
    .clk(clk), .rst(rst),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .cur_ptr(cur_ptr), .set_eop(set_eop), .set_err(set_err), .stop(stop),
    .mode(mode), .dir_cap(dir_cap), .big_end(big_end), .tbase(tbase)
  );

  pdd_walker #(.AW(AW), .CNT_W(CNT_W)) u_walker (
    .clk(clk), .rst(rst),
    .mode(mode), .dir_cap(dir_cap), .big_end(big_end), .tbase(tbase),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_err(mem_err),
    .mem_rdata(mem_rdata),
    .play_data(play_data), .play_valid(play_valid), .play_ready(play_ready),
    .cap_data(cap_data), .cap_valid(cap_valid), .cap_ready(cap_ready),
    .cur_ptr(cur_ptr), .set_eop(set_eop), .set_err(set_err), .stop(stop)
  );
endmodule

// File: tb/test_pcm_desc_dma.sv
module test_pcm_desc_dma;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        irq, mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ack = 1'b0, mem_err = 1'b0;
  logic [31:0] mem_rdata = '0, play_data;
  logic        play_valid, play_ready = 1'b0;
  logic [31:0] cap_data = '0;
  logic        cap_valid = 1'b0, cap_ready;

  pcm_desc_dma i_pcm_desc_dma (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_err(mem_err),
    .mem_rdata(mem_rdata), .play_data(play_data), .play_valid(play_valid),
    .play_ready(play_ready), .cap_data(cap_data), .cap_valid(cap_valid),
    .cap_ready(cap_ready)
  );

  always #(CLK_P/2) clk = ~clk;

  logic [31:0] mem [0:255];
  logic [31:0] plog [0:127];
  int   cyc = 0, pn = 0, nreq = 0, cap_cnt = 0, wd = 0;
  int   nchk = 0, nerr = 0;
  logic cap_hs = 1'b0, err_en = 1'b0;
  logic [31:0] err_addr = '0;

  function automatic logic [31:0] pat(input logic [31:0] a);
    return (a * 32'h0001_0003) ^ 32'h5A3C_96E1;
  endfunction
  function automatic logic [31:0] swp(input logic [31:0] w);
    return {w[23:16], w[31:24], w[7:0], w[15:8]};
  endfunction
  function automatic logic [31:0] capw(input int n);
    return 32'h1357_9BDF + 32'(n) * 32'h0104_0401;
  endfunction

  // behavioural memory and stream endpoints, all driven away from the edge
  always @(negedge clk) begin
    cyc = cyc + 1;
    mem_ack   = mem_req && (cyc[1:0] != 2'd0);
    mem_rdata = mem[mem_addr[9:2]];
    mem_err   = mem_ack && err_en && (mem_addr == err_addr);
    if (mem_ack && mem_we && !mem_err) mem[mem_addr[9:2]] = mem_wdata;
    if (mem_req) nreq = nreq + 1;
    play_ready = (cyc[2:0] != 3'd5);
    if (play_valid && play_ready) begin
      plog[pn[6:0]] = play_data;
      pn = pn + 1;
    end
    if (cap_hs) cap_cnt = cap_cnt + 1;
    cap_valid = (cyc[1:0] != 2'd1);
    cap_data  = capw(cap_cnt);
    cap_hs    = cap_valid && cap_ready;
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
  endtask

  always @(negedge clk) begin
    wd = wd + 1;
    if (wd > 150000) begin
      nchk = nchk + 1;
      nerr = nerr + 1;
      $display("FAIL watchdog: actual %0d cycles expected fewer", wd);
      summary();
      $finish;
    end
  end

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    nchk = nchk + 1;
    if (act !== exp) begin
      nerr = nerr + 1;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic wreg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rreg(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic put_desc(input int a, input logic [31:0] base, input logic [31:0] size);
    mem[a/4]     = base;
    mem[a/4 + 1] = size;
  endtask

  task automatic wait_stop(input string what);
    logic [31:0] v;
    v = 32'h1;
    for (int k = 0; k < 500; k++) begin
      rreg(2'd0, v);
      if (v[1:0] == 2'b00) break;
    end
    chk(what, {30'b0, v[1:0]}, 32'h0);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    logic [31:0] v;
    int p0, c0, r0;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R11 reset state
    rreg(2'd0, v); chk("R11 reset command", v, 32'h0);
    rreg(2'd1, v); chk("R11 reset status", v, 32'h0);
    rreg(2'd2, v); chk("R11 reset table", v, 32'h0);
    rreg(2'd3, v); chk("R11 reset pointer", v, 32'h0);
    chk("R11 reset irq", {31'b0, irq}, 32'h0);

    // playback sweep: counts 0..4 words (one with ragged low bits), both byte orders
    for (int be = 0; be < 2; be++) begin
      for (int n = 0; n < 5; n++) begin
        put_desc(0, 32'h100, 32'hC000_0000 | 32'(n*4 + ((n == 3) ? 2 : 0)));
        for (int i = 0; i < 8; i++) mem[64+i] = pat(32'h100 + 32'(4*i));
        p0 = pn;
        wreg(2'd2, 32'h0);
        wreg(2'd0, 32'(be*4 + 1));
        wait_stop("R6 stop at table end");
        chk("R2/R8 word count", 32'(pn - p0), 32'(n));
        for (int i = 0; i < n; i++)
          chk("R2/R4 play word", plog[(p0+i) % 128],
              (be == 1) ? swp(pat(32'h100 + 32'(4*i))) : pat(32'h100 + 32'(4*i)));
        chk("R5 irq level", {31'b0, irq}, (n > 0) ? 32'h1 : 32'h0);
        rreg(2'd1, v); chk("R5/R8 status", v, (n > 0) ? 32'h1 : 32'h0);
        rreg(2'd1, v); chk("R11 status cleared", v, 32'h0);
        rreg(2'd3, v); chk("R13 pointer", v, 32'h100 + 32'(4*n));
      end
    end

    // R1/R7 looping table: two regions then a jump (with stop flag) back to start
    put_desc(0, 32'h100, 32'h4000_0008);
    put_desc(8, 32'h180, 32'h0000_0004);
    put_desc(16, 32'h0, 32'hA000_0000);
    mem[64] = pat(32'h100); mem[65] = pat(32'h104); mem[96] = pat(32'h180);
    p0 = pn;
    wreg(2'd2, 32'h0);
    wreg(2'd0, 32'h1);
    for (int k = 0; k < 3000 && (pn - p0) < 10; k++) @(negedge clk);
    wreg(2'd0, 32'h3);
    r0 = nreq; c0 = pn;
    idle(40);
    chk("R9 no requests while paused", 32'(nreq - r0), 32'h0);
    chk("R9 no stream while paused", 32'(pn - c0), 32'h0);
    rreg(2'd0, v); chk("R9 pause readback", v, 32'h3);
    chk("R5 irq after marked region", {31'b0, irq}, 32'h1);
    wreg(2'd0, 32'h1);
    for (int k = 0; k < 3000 && (pn - p0) < 21; k++) @(negedge clk);
    chk("R7 loop kept running", 32'((pn - p0) >= 21), 32'h1);
    for (int i = 0; i < 21; i++)
      chk("R1/R7/R9 loop order", plog[(p0+i) % 128],
          (i % 3 == 2) ? pat(32'h180) : pat(32'h100 + 32'(4*(i % 3))));

    // R10 halt, then restart from a new table address
    wreg(2'd0, 32'h0);
    r0 = nreq;
    idle(40);
    chk("R10 no requests after halt", 32'(nreq - r0), 32'h0);
    rreg(2'd1, v);
    put_desc(48, 32'h1C0, 32'hC000_0008);
    mem[112] = pat(32'h1C0); mem[113] = pat(32'h1C4);
    p0 = pn;
    wreg(2'd2, 32'h30);
    wreg(2'd0, 32'h1);
    wait_stop("R10 restart run ends");
    chk("R10 restart count", 32'(pn - p0), 32'h2);
    chk("R10 restart first word", plog[p0 % 128], pat(32'h1C0));
    chk("R10 restart second word", plog[(p0+1) % 128], pat(32'h1C4));
    rreg(2'd1, v); chk("R5 restart status", v, 32'h1);

    // capture sweep
    for (int be = 0; be < 2; be++) begin
      for (int n = 1; n < 4; n++) begin
        put_desc(32, 32'h140, 32'hC000_0000 | 32'(4*n));
        for (int i = 0; i < 8; i++) mem[80+i] = '0;
        c0 = cap_cnt;
        wreg(2'd2, 32'h20);
        wreg(2'd0, 32'(8 + be*4 + 1));
        wait_stop("R6 capture stop");
        for (int i = 0; i < n; i++)
          chk("R3/R4 captured word", mem[80+i],
              (be == 1) ? swp(capw(c0 + i)) : capw(c0 + i));
        chk("R3 no write past region", mem[80+n], 32'h0);
        rreg(2'd1, v); chk("R5 capture status", v, 32'h1);
      end
    end

    // R12 bus error on the third word of a region
    put_desc(64, 32'h1E0, 32'h8000_0010);
    for (int i = 0; i < 4; i++) mem[120+i] = pat(32'h1E0 + 32'(4*i));
    err_addr = 32'h1E8; err_en = 1'b1;
    p0 = pn;
    wreg(2'd2, 32'h40);
    wreg(2'd0, 32'h1);
    wait_stop("R12 error stops channel");
    err_en = 1'b0;
    chk("R12 words before error", 32'(pn - p0), 32'h2);
    chk("R12 irq", {31'b0, irq}, 32'h1);
    rreg(2'd1, v); chk("R12 status error bit", v, 32'h2);
    rreg(2'd3, v); chk("R13 pointer at fault", v, 32'h1E8);

    summary();
    $finish;
  end
endmodule